// File: doc/BRIEF.md
# Dual-Path Level Interrupt Combiner

This block gathers a set of level-sensitive interrupt request lines into one normal request and one fast request for a processor. Both request outputs are active-low. On the normal path, each source bit is ORed with a bit of a software request register to form a raw pending word. The raw word is then masked by an enable register. The normal request is asserted while any masked bit is set. The fast path carries a single source line with its own enable bit and drives a separate fast request.

Each path has its own simple register port. A port has an address, a write strobe with write data, and a read strobe with registered read data. The two ports work independently of each other, so firmware for the normal path and firmware for the fast path never contend for an access slot. Enable bits are never written directly. One address sets the bits that are written as 1, and another address clears them, so two software agents cannot lose each other's updates through a read-modify-write.

Register offsets (byte addresses) are the same on both ports. Offset 0x00 returns the masked pending bits. Offset 0x04 returns the raw pending bits. Offset 0x08 reads the enable mask, and a write there sets enable bits. A write to offset 0x0C clears enable bits. A write to offset 0x10 loads the software request register, and this register exists on the normal port only. The fast port returns its single bit in bit 0 of the read data, and bits 31:1 read as 0.

Top module: `dual_irq_ctl`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, the following happens after that edge: `irq_n` and `fiq_n` are 1, both read data buses are 0, and every enable bit and software request bit is 0.
- R2: A normal-port read of offset 0x04 returns `src_lvl | soft`, one bit per source, where soft is the software request register. A fast-port read of 0x04 returns `fsrc_lvl` in bit 0.
- R3: A read of offset 0x00 returns the raw pending bits ANDed with the enable mask. This holds on both ports, and on the fast port the result is in bit 0.
- R4: A write to offset 0x08 ORs the write data into the enable mask. A read of 0x08 returns the current mask.
- R5: A write to offset 0x0C clears every enable bit whose write-data bit is 1 and leaves the other enable bits unchanged.
- R6: A normal-port write to offset 0x10 replaces the software request register with the write data. Each bit of that register then acts as an extra source for the same bit position.
- R7: After each clock edge out of reset, `irq_n` is 0 exactly when the masked normal pending word was nonzero before that edge. A source change therefore appears on `irq_n` one cycle later. An enable or software write appears two edges after it is presented.
- R8: After each clock edge out of reset, `fiq_n` is 0 exactly when `fsrc_lvl` and the fast enable bit were both 1 before that edge.
- R9: Writes to offsets 0x00, 0x04 and any unmapped offset have no effect. Reads of 0x0C, 0x10 and any unmapped offset return 0.
- R10: Read data is registered. It reflects the state before any write presented in the same cycle, and it is 0 in any cycle that follows a cycle with no read strobe.
- R11: The fast port has no software request register, so a fast-port write to 0x10 has no effect and a fast-port read of 0x10 returns 0. Neither port's writes alter the other path's state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_lvl | input | NSRC (32) | Normal interrupt sources, active high |
| fsrc_lvl | input | 1 | Fast interrupt source, active high |
| n_addr | input | AW (5) | Normal port byte address |
| n_wr | input | 1 | Normal port write strobe |
| n_wdata | input | DW (32) | Normal port write data |
| n_rd | input | 1 | Normal port read strobe |
| n_rdata | output | DW (32) | Normal port read data, registered |
| f_addr | input | AW (5) | Fast port byte address |
| f_wr | input | 1 | Fast port write strobe |
| f_wdata | input | DW (32) | Fast port write data, bit 0 used |
| f_rd | input | 1 | Fast port read strobe |
| f_rdata | output | DW (32) | Fast port read data, registered |
| irq_n | output | 1 | Normal interrupt request, active low |
| fiq_n | output | 1 | Fast interrupt request, active low |

## Verification
Source levels can change in the same cycle as an enable-clear write. The bench provokes this by raising a source bit in the very cycle that clears its enable. It expects `irq_n` to drop for exactly one cycle, because the request is built from the mask as it stood before the edge. A read and a write to the enable offset are also issued together, and the bench expects the read to return the pre-write mask. A cycle-accurate behavioural model in the bench predicts both outputs and both read buses on every clock, through directed cases and a long random mix of traffic on both ports.

// File: rtl/dual_irq_pkg.sv
package dual_irq_pkg;
   // byte offsets shared by both register ports
   localparam int unsigned OFS_PEND_MASKED = 0;
   localparam int unsigned OFS_PEND_RAW    = 4;
   localparam int unsigned OFS_ENA_SET     = 8;
   localparam int unsigned OFS_ENA_CLR     = 12;
   localparam int unsigned OFS_SOFT_REQ    = 16;
   localparam int unsigned MIN_AW          = 5;
endpackage

// File: rtl/irq_bank.sv
module irq_bank
   import dual_irq_pkg::*;
#(
   parameter int unsigned NSRC     = 32,
   parameter int unsigned DW       = 32,
   parameter int unsigned AW       = 5,
   parameter bit          HAS_SOFT = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [NSRC-1:0] src,
   input  logic [AW-1:0]   addr,
   input  logic            wr,
   input  logic [DW-1:0]   wdata,
   input  logic            rd,
   output logic [DW-1:0]   rdata,
   output logic            req
);
   localparam logic [AW-1:0] A_MSK = AW'(OFS_PEND_MASKED);
   localparam logic [AW-1:0] A_RAW = AW'(OFS_PEND_RAW);
   localparam logic [AW-1:0] A_SET = AW'(OFS_ENA_SET);
   localparam logic [AW-1:0] A_CLR = AW'(OFS_ENA_CLR);
   localparam logic [AW-1:0] A_SFT = AW'(OFS_SOFT_REQ);

   if (NSRC == 0 || NSRC > DW) begin : g_bad_width
      $error("irq_bank: NSRC must be 1..DW");
   end
   if (AW < MIN_AW) begin : g_bad_aw
      $error("irq_bank: AW too small for register map");
   end

   logic [NSRC-1:0] en_q;
   logic [NSRC-1:0] soft_bits;
   logic [NSRC-1:0] raw;
   logic [NSRC-1:0] masked;
   logic [DW-1:0]   rd_sel;
   logic            hit_set;
   logic            hit_clr;
   logic            unused_wdata;

   assign unused_wdata = ^wdata;
   assign hit_set = wr && (addr == A_SET);
   assign hit_clr = wr && (addr == A_CLR);

   always_ff @(posedge clk) begin
      if (rst)          en_q <= '0;
      else if (hit_set) en_q <= en_q | wdata[NSRC-1:0];
      else if (hit_clr) en_q <= en_q & ~wdata[NSRC-1:0];
   end

   if (HAS_SOFT) begin : g_soft
      logic [NSRC-1:0] soft_q;
      always_ff @(posedge clk) begin
         if (rst)                        soft_q <= '0;
         else if (wr && addr == A_SFT)   soft_q <= wdata[NSRC-1:0];
      end
      assign soft_bits = soft_q;

      assert_soft_load_R6: assert property (@(posedge clk) disable iff (rst)
         (wr && addr == A_SFT) |=> (soft_q == $past(wdata[NSRC-1:0])));
   end else begin : g_no_soft
      assign soft_bits = '0;
   end

   assign raw    = src | soft_bits;
   assign masked = raw & en_q;
   assign req    = |masked;

   always_comb begin
      rd_sel = '0;
      case (addr)
         A_MSK:   rd_sel = DW'(masked);
         A_RAW:   rd_sel = DW'(raw);
         A_SET:   rd_sel = DW'(en_q);
         default: rd_sel = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)     rdata <= '0;
      else if (rd) rdata <= rd_sel;
      else         rdata <= '0;
   end

   assert_ena_set_R4: assert property (@(posedge clk) disable iff (rst)
      hit_set |=> ((en_q & $past(wdata[NSRC-1:0])) == $past(wdata[NSRC-1:0])));
   assert_ena_clr_R5: assert property (@(posedge clk) disable iff (rst)
      hit_clr |=> ((en_q & $past(wdata[NSRC-1:0])) == '0));
   assert_status_wr_ignored_R9: assert property (@(posedge clk) disable iff (rst)
      (wr && (addr == A_MSK || addr == A_RAW)) |=> $stable(en_q));
   assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (rst)
      !rd |=> (rdata == '0));
endmodule

// File: rtl/irq_req_flop.sv
module irq_req_flop (
   input  logic clk,
   input  logic rst,
   input  logic req,
   output logic req_n
);
   always_ff @(posedge clk) begin
      if (rst) req_n <= 1'b1;
      else     req_n <= ~req;
   end

   // R7 for the normal path, R8 for the fast path
   assert_req_delay_R7: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (req_n != $past(req)));
endmodule

// File: rtl/dual_irq_ctl.sv
module dual_irq_ctl
   import dual_irq_pkg::*;
#(
   parameter int unsigned NSRC = 32,
   parameter int unsigned DW   = 32,
   parameter int unsigned AW   = 5
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [NSRC-1:0] src_lvl,
   input  logic            fsrc_lvl,
   input  logic [AW-1:0]   n_addr,
   input  logic            n_wr,
   input  logic [DW-1:0]   n_wdata,
   input  logic            n_rd,
   output logic [DW-1:0]   n_rdata,
   input  logic [AW-1:0]   f_addr,
   input  logic            f_wr,
   input  logic [DW-1:0]   f_wdata,
   input  logic            f_rd,
   output logic [DW-1:0]   f_rdata,
   output logic            irq_n,
   output logic            fiq_n
);
   localparam int unsigned FAST_W = 1;

   if (AW < MIN_AW) begin : g_bad_aw
      $error("dual_irq_ctl: AW too small");
   end

   logic n_req;
   logic f_req;

   irq_bank #(.NSRC(NSRC), .DW(DW), .AW(AW), .HAS_SOFT(1'b1)) u_norm (
      .clk(clk), .rst(rst), .src(src_lvl),
      .addr(n_addr), .wr(n_wr), .wdata(n_wdata), .rd(n_rd),
      .rdata(n_rdata), .req(n_req));

   irq_bank #(.NSRC(FAST_W), .DW(DW), .AW(AW), .HAS_SOFT(1'b0)) u_fast (
      .clk(clk), .rst(rst), .src(fsrc_lvl),
      .addr(f_addr), .wr(f_wr), .wdata(f_wdata), .rd(f_rd),
      .rdata(f_rdata), .req(f_req));

   irq_req_flop u_irq_out (.clk(clk), .rst(rst), .req(n_req), .req_n(irq_n));
   irq_req_flop u_fiq_out (.clk(clk), .rst(rst), .req(f_req), .req_n(fiq_n));

   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (irq_n && fiq_n));
   assert_fiq_idle_R8: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(fsrc_lvl)) |-> fiq_n);
   assert_fast_rd_width_R11: assert property (@(posedge clk) disable iff (rst)
      f_rdata[DW-1:1] == '0);
endmodule

// File: tb/dual_irq_ctl_test.sv
module dual_irq_ctl_test;
   timeunit 1ns;
   timeprecision 1ps;

   logic        clk = 1'b0;
   always #2.5 clk = ~clk;

   logic        rst = 1'b1;
   logic [31:0] src = '0;
   logic        fsrc = 1'b0;
   logic [4:0]  n_addr = '0, f_addr = '0;
   logic        n_wr = 1'b0, n_rd = 1'b0, f_wr = 1'b0, f_rd = 1'b0;
   logic [31:0] n_wdata = '0, f_wdata = '0;
   logic [31:0] n_rdata, f_rdata;
   logic        irq_n, fiq_n;

   dual_irq_ctl uut (
      .clk(clk), .rst(rst), .src_lvl(src), .fsrc_lvl(fsrc),
      .n_addr(n_addr), .n_wr(n_wr), .n_wdata(n_wdata), .n_rd(n_rd), .n_rdata(n_rdata),
      .f_addr(f_addr), .f_wr(f_wr), .f_wdata(f_wdata), .f_rd(f_rd), .f_rdata(f_rdata),
      .irq_n(irq_n), .fiq_n(fiq_n));

   // behavioural reference state
   logic [31:0] m_en = '0, m_soft = '0;
   logic        m_fen = 1'b0;
   logic [31:0] e_nrd, e_frd;
   logic        e_irq, e_fiq;
   int          vectors = 0, miscompares = 0;
   string       req_tag = "R1";
   bit          finished = 0;

   task automatic chk(string what, logic [31:0] got, logic [31:0] exp);
      vectors++;
      if (got !== exp) begin
         miscompares++;
         $display("FAIL %s %s got %h exp %h", req_tag, what, got, exp);
      end
   endtask

   task automatic step();
      logic [31:0] raw, msk;
      if (rst) begin
         m_en = '0; m_soft = '0; m_fen = 1'b0;
         e_irq = 1'b1; e_fiq = 1'b1; e_nrd = '0; e_frd = '0;
      end else begin
         raw = src | m_soft;
         msk = raw & m_en;
         e_irq = (msk == 0);
         e_fiq = !(fsrc && m_fen);
         e_nrd = '0;
         if (n_rd) begin
            if (n_addr == 5'h00) e_nrd = msk;
            else if (n_addr == 5'h04) e_nrd = raw;
            else if (n_addr == 5'h08) e_nrd = m_en;
         end
         e_frd = '0;
         if (f_rd) begin
            if (f_addr == 5'h00) e_frd = {31'b0, fsrc & m_fen};
            else if (f_addr == 5'h04) e_frd = {31'b0, fsrc};
            else if (f_addr == 5'h08) e_frd = {31'b0, m_fen};
         end
         if (n_wr) begin
            if (n_addr == 5'h08) m_en = m_en | n_wdata;
            else if (n_addr == 5'h0C) m_en = m_en & ~n_wdata;
            else if (n_addr == 5'h10) m_soft = n_wdata;
         end
         if (f_wr) begin
            if (f_addr == 5'h08) m_fen = m_fen | f_wdata[0];
            else if (f_addr == 5'h0C) m_fen = m_fen & ~f_wdata[0];
         end
      end
      @(posedge clk);
      #1;
      chk("irq_n", {31'b0, irq_n}, {31'b0, e_irq});
      chk("fiq_n", {31'b0, fiq_n}, {31'b0, e_fiq});
      chk("n_rdata", n_rdata, e_nrd);
      chk("f_rdata", f_rdata, e_frd);
   endtask

   task automatic idle();
      n_wr = 0; n_rd = 0; f_wr = 0; f_rd = 0;
   endtask

   task automatic nwr(logic [4:0] a, logic [31:0] d);
      n_addr = a; n_wdata = d; n_wr = 1; step(); idle();
   endtask
   task automatic nrd(logic [4:0] a);
      n_addr = a; n_rd = 1; step(); idle();
   endtask
   task automatic fwr(logic [4:0] a, logic [31:0] d);
      f_addr = a; f_wdata = d; f_wr = 1; step(); idle();
   endtask
   task automatic frd(logic [4:0] a);
      f_addr = a; f_rd = 1; step(); idle();
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   initial begin
      #1000000;
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog run did not complete");
         finish_run();
      end
   end

   initial begin
      #1;
      // R1: reset state
      req_tag = "R1";
      repeat (3) step();
      rst = 0;
      step(); step();

      // R4: enable set and readback
      req_tag = "R4";
      nwr(5'h08, 32'h0000_00F0);
      nrd(5'h08);
      nwr(5'h08, 32'h0F0F_0000);
      nrd(5'h08);

      // R2: raw status under several patterns
      req_tag = "R2";
      src = 32'hA5A5_0001; step(); nrd(5'h04);
      src = 32'h0000_0000; step(); nrd(5'h04);
      src = 32'hFFFF_FFFF; nrd(5'h04);

      // R3 / R7: masked status and request output
      req_tag = "R3";
      src = 32'h0000_0010; nrd(5'h00); step();
      req_tag = "R7";
      src = 32'h0000_0001; step(); step();
      src = 32'h0100_0000; step(); nrd(5'h00);

      // R5: enable clear
      req_tag = "R5";
      nwr(5'h0C, 32'h0100_0010); nrd(5'h08); nrd(5'h00);
      src = '0; step();

      // R6: software request
      req_tag = "R6";
      nwr(5'h10, 32'h8000_0002);
      nrd(5'h04); nrd(5'h00);
      nwr(5'h08, 32'h8000_0000); step(); nrd(5'h00);
      nwr(5'h10, 32'h0); step(); nrd(5'h04);

      // R9: ignored writes, reserved reads
      req_tag = "R9";
      nwr(5'h00, 32'hFFFF_FFFF); nwr(5'h04, 32'hFFFF_FFFF);
      nwr(5'h14, 32'hFFFF_FFFF); nwr(5'h1C, 32'hFFFF_FFFF);
      nrd(5'h08); nrd(5'h0C); nrd(5'h10); nrd(5'h14); nrd(5'h1C); nrd(5'h02);

      // R8: fast path
      req_tag = "R8";
      fsrc = 1; step(); frd(5'h04); frd(5'h00);
      fwr(5'h08, 32'hFFFF_FFFF); step(); frd(5'h00); frd(5'h08);
      fsrc = 0; step(); step();
      fsrc = 1; step();
      fwr(5'h0C, 32'h1); step();

      // R11: fast port isolation and no soft register
      req_tag = "R11";
      fwr(5'h10, 32'hFFFF_FFFF); frd(5'h10); frd(5'h04);
      fwr(5'h08, 32'hFFFF_FFFF); nrd(5'h08); nrd(5'h04);
      nwr(5'h0C, 32'hFFFF_FFFF); frd(5'h08);

      // R10: read and write in the same cycle returns old value
      req_tag = "R10";
      n_addr = 5'h08; n_wdata = 32'h0000_5500; n_wr = 1; n_rd = 1; step(); idle();
      nrd(5'h08); step();

      // R7: source rises in the same cycle its enable is cleared
      req_tag = "R7";
      src = 32'h0000_0100;
      n_addr = 5'h0C; n_wdata = 32'h0000_0100; n_wr = 1; step(); idle();
      step(); step();
      src = '0;

      // mixed random traffic on both ports
      req_tag = "R10";
      for (int i = 0; i < 400; i++) begin
         logic [4:0] al [6];
         al = '{5'h00, 5'h04, 5'h08, 5'h0C, 5'h10, 5'h14};
         src     = $urandom() & $urandom();
         fsrc    = 1'($urandom());
         n_addr  = al[$urandom() % 6];
         f_addr  = al[$urandom() % 6];
         n_wdata = $urandom() & $urandom();
         f_wdata = $urandom();
         n_wr    = 1'($urandom());
         n_rd    = 1'($urandom());
         f_wr    = 1'($urandom());
         f_rd    = 1'($urandom());
         step();
      end
      idle();

      // R1: reset mid-run clears everything
      req_tag = "R1";
      nwr(5'h08, 32'hFFFF_FFFF); fwr(5'h08, 32'h1);
      rst = 1; step(); step();
      rst = 0; src = 32'hFFFF_FFFF; fsrc = 1;
      step(); nrd(5'h08); frd(5'h08); step();

      finish_run();
   end
endmodule